// File: doc/BRIEF.md
# Raster Timing Generator with Border and Window Regions

This block produces the horizontal and vertical timing of a raster display. A pixel counter and a line counter run over a programmable line length and field length. Fixed-width hsync and vsync pulses, a border-region flag, an inner display-window flag, a field indicator, a broadcast-standard flag and a single-cycle end-of-field event are derived from those counters. Software programs the timing through a small write port. Each write lands in a shadow register bank. The whole bank is copied to the active set only on the last clock of a field, so a frame is never drawn with a mix of old and new settings.

The window sits inside the border area. Where the window is present it takes priority over the border. Blanking does not stop the timing. It removes the window, so the border covers everything inside its limits. Interlace halves the programmed line total to give the field length, and it alternates between two window start lines. Line doubling makes the window twice as tall in output lines. The border colour is stored like any other register and is presented on an output.

Register map on `wr_addr`. Fields named "hi" are in bits 31:16 and fields named "lo" are in bits 15:0.

| Address | Contents |
|---|---|
| 0 | Totals: hi is the line total, lo is the clocks per line |
| 1 | Horizontal border: hi is the start, lo is the stop |
| 2 | Vertical border: hi is the start, lo is the stop |
| 3 | Window start column, in lo |
| 4 | Window start line: lo is used in field 0, hi in field 1 |
| 5 | Window size: hi is the height, lo is the width |
| 6 | Control: bit0 enables the display, bit1 doubles lines, bit3 blanks, bit4 selects interlace |
| 7 | Border colour, all 32 bits |

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 to max(clocks per line, 2)-1 and then wraps, advancing the line counter. The line counter wraps after the last line of a field. hsync is high while the pixel counter is below HSYNC_W. vsync is high while the line counter is below VSYNC_L.
- R2: A write updates only the shadow bank. The active set takes the whole shadow bank on the edge that ends a field. vblank is high for exactly the last clock of each field, that is, the last pixel of the last line.
- R3: border_active is high when the display is enabled (control bit0), the pixel counter lies in [hborder start, hborder stop), the line counter lies in [vborder start, vborder stop), and window_active is low.
- R4: window_active is high when the display is enabled and not blanked, the pixel counter lies in [window column, window column + width), and the line counter lies in [window start line, start line + effective height).
- R5: With control bit3 set, window_active stays low and border_active covers the whole border rectangle.
- R6: With control bit1 set, the effective window height is twice the programmed height.
- R7: With control bit4 set, a field lasts (line total >> 1) lines, and field toggles at every end of field. Field 0 uses the lo start line and field 1 uses the hi start line. Without interlace, field returns to 0 at the end of each field.
- R8: std_625 is high when the per-field line count (after halving for interlace) is greater than STD_SPLIT (287, which is midway between 312 and 262).
- R9: With control bit0 clear, border_active and window_active both stay low. The sync outputs continue.
- R10: border_color shows the active colour register and changes only at an end of field.
- R11: Reset clears both counters and the field, loads the totals register with RST_VTOT/RST_HTOT, and clears every other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe to the shadow bank |
| wr_addr | input | 3 | Register select |
| wr_data | input | 2*CW | Write data |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| border_active | output | 1 | Inside the border, outside the window |
| window_active | output | 1 | Inside the display window |
| field | output | 1 | Current interlace field |
| vblank | output | 1 | Last clock of the field; this is when the shadow bank is loaded |
| std_625 | output | 1 | Per-field line count selects the 625-line standard |
| border_color | output | 2*CW | Active border colour |

## Verification
A wrong counter limit or a wrong load instant first shows as a vblank pulse in the wrong cycle. The cycle-by-cycle model catches that within one line of the fault. A shadow bank that leaks into the active set shows up at once as border_color or a region flag changing in the middle of a field, which is far earlier than the next retrace. A window bound, a field-half selection or a doubling error changes window_active on the first affected pixel. The bench confirms this with per-field counts of window and border cycles.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CW        = 16,
  parameter int HSYNC_W   = 64,
  parameter int VSYNC_L   = 3,
  parameter int RST_HTOT  = 857,
  parameter int RST_VTOT  = 262,
  parameter int STD_SPLIT = 287
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [2*CW-1:0] wr_data,
  output logic            hsync,
  output logic            vsync,
  output logic            border_active,
  output logic            window_active,
  output logic            field,
  output logic            vblank,
  output logic            std_625,
  output logic [2*CW-1:0] border_color
);
  localparam int DW    = 2 * CW;
  localparam int NREG  = 8;
  localparam int A_TOT = 0, A_HB = 1, A_VB = 2, A_WH = 3, A_WV = 4, A_WS = 5, A_CTL = 6, A_COL = 7;
  localparam logic [DW-1:0] TOT_RST = {CW'(RST_VTOT), CW'(RST_HTOT)};

  logic [DW-1:0] sh [NREG];
  logic [DW-1:0] ac [NREG];
  logic [CW-1:0] hc, vc;
  logic          fld;

  logic en_on, dbl_on, blank_on, ilace_on;
  assign en_on    = ac[A_CTL][0];
  assign dbl_on   = ac[A_CTL][1];
  assign blank_on = ac[A_CTL][3];
  assign ilace_on = ac[A_CTL][4];

  logic unused_bits;
  assign unused_bits = ^{ac[A_WH][DW-1:CW], ac[A_CTL][DW-1:5], ac[A_CTL][2]};

  logic [CW-1:0] htot, vtot, vfield, hlim, vlim;
  assign htot   = ac[A_TOT][CW-1:0];
  assign vtot   = ac[A_TOT][DW-1:CW];
  assign vfield = ilace_on ? (vtot >> 1) : vtot;
  assign hlim   = (htot < CW'(2)) ? CW'(2) : htot;
  assign vlim   = (vfield == '0) ? CW'(1) : vfield;

  logic h_last, v_last;
  assign h_last = (hc == hlim - CW'(1));
  assign v_last = (vc == vlim - CW'(1));
  assign vblank = h_last & v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        sh[i] <= (i == A_TOT) ? TOT_RST : '0;
        ac[i] <= (i == A_TOT) ? TOT_RST : '0;
      end
    end else begin
      if (wr_en) sh[wr_addr] <= wr_data;
      if (vblank)
        for (int i = 0; i < NREG; i++) ac[i] <= sh[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc  <= '0;
      vc  <= '0;
      fld <= 1'b0;
    end else begin
      if (h_last) begin
        hc <= '0;
        vc <= v_last ? '0 : vc + CW'(1);
      end else begin
        hc <= hc + CW'(1);
      end
      if (vblank) fld <= ilace_on ? ~fld : 1'b0;
    end
  end

  function automatic logic span(input logic [CW-1:0] p, input logic [CW-1:0] lo, input logic [CW-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  function automatic logic in_win(input logic [CW-1:0] p, input logic [CW-1:0] lo, input logic [CW:0] len);
    logic [CW+1:0] e;
    e = {2'b00, lo} + {1'b0, len};
    return (p >= lo) && ({2'b00, p} < e);
  endfunction

  logic [CW-1:0] wv_start;
  logic [CW:0]   hgt_eff;
  assign wv_start = fld ? ac[A_WV][DW-1:CW] : ac[A_WV][CW-1:0];
  assign hgt_eff  = dbl_on ? {ac[A_WS][DW-1:CW], 1'b0} : {1'b0, ac[A_WS][DW-1:CW]};

  logic in_bord, win_in;
  assign in_bord = en_on
                 & span(hc, ac[A_HB][DW-1:CW], ac[A_HB][CW-1:0])
                 & span(vc, ac[A_VB][DW-1:CW], ac[A_VB][CW-1:0]);
  assign win_in  = en_on & ~blank_on
                 & in_win(hc, ac[A_WH][CW-1:0], {1'b0, ac[A_WS][CW-1:0]})
                 & in_win(vc, wv_start, hgt_eff);

  assign window_active = win_in;
  assign border_active = in_bord & ~win_in;
  assign hsync         = int'(hc) < HSYNC_W;
  assign vsync         = int'(vc) < VSYNC_L;
  assign field         = fld;
  assign std_625       = int'(vfield) > STD_SPLIT;
  assign border_color  = ac[A_COL];
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vblank,
  input logic            field,
  input logic            window_active,
  input logic            border_active,
  input logic            blank_on,
  input logic [CW-1:0]   hc,
  input logic [CW-1:0]   vc,
  input logic [2*CW-1:0] border_color
);
  AST_WRAP_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n) vblank |=> (hc == '0 && vc == '0)); // R1
  AST_VBLANK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) vblank |=> !vblank); // R2
  AST_REGION_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(window_active && border_active)); // R3
  AST_BLANK_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n) blank_on |-> !window_active); // R5
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !vblank |=> $stable(field)); // R7
  AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !vblank |=> $stable(border_color)); // R10
endmodule

bind raster_timing_gen raster_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .field(field),
  .window_active(window_active), .border_active(border_active),
  .blank_on(blank_on), .hc(hc), .vc(vc), .border_color(border_color)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int CW = 16, DW = 32, HSW = 3, VSL = 2, RH = 10, RV = 6, SPLIT = 287;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic hsync, vsync, border_active, window_active, field, vblank, std_625;
  logic [DW-1:0] border_color;

  always #10 clk = ~clk;

  raster_timing_gen #(.CW(CW), .HSYNC_W(HSW), .VSYNC_L(VSL), .RST_HTOT(RH), .RST_VTOT(RV), .STD_SPLIT(SPLIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .border_active(border_active), .window_active(window_active),
    .field(field), .vblank(vblank), .std_625(std_625), .border_color(border_color));

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] msh [8];
  logic [31:0] mac [8];
  int mh = 0, mv = 0;
  bit mf = 0;

  task automatic chk(input int got, input int exp, input string tag);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int f_hl();
    int t = int'(mac[0][15:0]);
    return (t < 2) ? 2 : t;
  endfunction
  function automatic int f_vf();
    int t = int'(mac[0][31:16]);
    return mac[6][4] ? t / 2 : t;
  endfunction
  function automatic int f_vl();
    return (f_vf() == 0) ? 1 : f_vf();
  endfunction

  int hl_n, vl_n;
  bit eof_n, il_n;
  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mf = 0;
      for (int i = 0; i < 8; i++) begin
        msh[i] = (i == 0) ? {16'(RV), 16'(RH)} : 32'd0;
        mac[i] = msh[i];
      end
    end else begin
      hl_n = f_hl(); vl_n = f_vl();
      eof_n = (mh == hl_n - 1) && (mv == vl_n - 1);
      il_n = mac[6][4];
      if (mh == hl_n - 1) begin
        mh = 0;
        mv = (mv == vl_n - 1) ? 0 : mv + 1;
      end else mh = mh + 1;
      if (eof_n) begin
        mf = il_n ? ~mf : 1'b0;
        for (int i = 0; i < 8; i++) mac[i] = msh[i];
      end
      if (wr_en) msh[wr_addr] = wr_data;
    end
  end

  int e_wvs, e_hgt, e_wh, e_ww;
  bit e_en, e_win, e_brd;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      e_en  = mac[6][0];
      e_wvs = mf ? int'(mac[4][31:16]) : int'(mac[4][15:0]);
      e_hgt = int'(mac[5][31:16]) * (mac[6][1] ? 2 : 1);
      e_wh  = int'(mac[3][15:0]);
      e_ww  = int'(mac[5][15:0]);
      e_win = e_en && !mac[6][3] && mh >= e_wh && mh < e_wh + e_ww && mv >= e_wvs && mv < e_wvs + e_hgt;
      e_brd = e_en && !e_win
              && mh >= int'(mac[1][31:16]) && mh < int'(mac[1][15:0])
              && mv >= int'(mac[2][31:16]) && mv < int'(mac[2][15:0]);
      chk(hsync, mh < HSW, "R1 hsync");
      chk(vsync, mv < VSL, "R1 vsync");
      chk(vblank, (mh == f_hl() - 1) && (mv == f_vl() - 1), "R2 vblank");
      chk(border_active, e_brd, "R3 border_active");
      chk(window_active, e_win, "R4 window_active");
      chk(field, mf, "R7 field");
      chk(std_625, f_vf() > SPLIT, "R8 std_625");
      chk(border_color, mac[7], "R10 border_color");
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_vb();
    @(negedge clk);
    while (!vblank) @(negedge clk);
  endtask

  task automatic count_field(output int w, output int b);
    w = 0; b = 0;
    do begin
      @(negedge clk);
      w += window_active;
      b += border_active;
    end while (!vblank);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int w, b;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(hsync, 1, "R11 reset hsync");
    chk(vsync, 1, "R11 reset vsync");
    chk(border_active, 0, "R11 reset border");
    chk(window_active, 0, "R11 reset window");
    chk(field, 0, "R11 reset field");
    chk(vblank, 0, "R11 reset vblank");
    chk(border_color, 0, "R11 reset colour");

    wr(0, {16'd20, 16'd24});
    wr(1, {16'd2, 16'd22});
    wr(2, {16'd1, 16'd18});
    wr(3, 32'd6);
    wr(4, {16'd9, 16'd4});
    wr(5, {16'd8, 16'd10});
    wr(6, 32'h1);
    wr(7, 32'h00ABCDEF);
    chk(border_color, 0, "R2 shadow not live");
    chk(border_active, 0, "R2 enable not live");

    wait_vb();
    count_field(w, b);
    chk(w, 80, "R4 window cycles per field");
    chk(b, 260, "R3 border cycles per field");

    wr(6, 32'h9);
    wait_vb();
    count_field(w, b);
    chk(w, 0, "R5 blank window cycles");
    chk(b, 340, "R5 blank border cycles");

    wr(6, 32'h3);
    wait_vb();
    count_field(w, b);
    chk(w, 160, "R6 doubled window cycles");

    wr(0, {16'd40, 16'd24});
    wr(6, 32'h11);
    wait_vb();
    count_field(w, b);
    chk(w, 80, "R7 interlaced field 0 window");
    @(negedge clk);
    chk(field, 1, "R7 field toggles");
    wait_vb();

    wr(0, {16'd600, 16'd12});
    wait_vb();
    @(negedge clk);
    chk(std_625, 1, "R8 300 lines per field");
    wr(0, {16'd560, 16'd12});
    wait_vb();
    @(negedge clk);
    chk(std_625, 0, "R8 280 lines per field");

    wr(0, {16'd20, 16'd24});
    wr(6, 32'h0);
    wait_vb();
    wait_vb();
    count_field(w, b);
    chk(w + b, 0, "R9 disabled regions");

    wait_vb();
    wr(7, 32'h00123456);
    chk(border_color, 32'h00ABCDEF, "R2 write on eof stays in shadow");
    wait_vb();
    @(negedge clk);
    chk(border_color, 32'h00123456, "R10 colour loads at next eof");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule